// File: doc/BRIEF.md
# Receive Byte Ordering Realigner

This block sits behind a 1:2 byte deserializer on a receive path. Each clock it takes one parallel word made of two symbols, each 8 or 10 bits wide, where the lower lane holds the symbol that arrived first. It looks for a fixed ordering symbol. The correct place for that symbol is the lower lane. When the symbol shows up in the upper lane, the block injects one pad symbol into the stream. That moves the ordering symbol, and every symbol after it, over by one lane, so the ordering symbol lands in the lower lane of the next output word. After an injection the block keeps running in this shifted phase. Each output word is then built from the current lower symbol and the upper symbol held over from the previous valid word.

An ordering operation can start in one of two ways, chosen by a parameter. In automatic mode the block orders once on the first match after a link-synchronised input goes high. In manual mode a rising edge on an enable input arms the block for one operation. A one-cycle flag marks the output word of each ordering operation. Output latency is a fixed single cycle, and a valid bit travels alongside the data.

Top module: `rx_lane_orderer`

## Requirements
- R1: While reset is asserted, `out_valid`, `order_flag` and `out_data` are all zero, and the block restarts in the direct (unshifted) phase.
- R2: `out_valid` equals `in_valid` delayed by one cycle. In the direct phase, each valid output word equals the input word of the previous cycle.
- R3: When an ordering operation finds the ordering symbol in the upper lane (bits [2*SYM_W-1:SYM_W]) during the direct phase, the output word of that cycle is {upper = input lower symbol, lower = PAD_SYM}. `order_flag` is high with that word.
- R4: After a pad has been inserted, every later valid output word is {upper = current input lower symbol, lower = upper symbol of the previous valid input word}. The ordering symbol therefore appears in the lower lane of the next valid output word.
- R5: When an ordering operation finds the ordering symbol in the lower lane (bits [SYM_W-1:0]) during the direct phase, no pad is inserted and the word passes through unchanged with `order_flag` high. If both lanes match, the lower lane wins.
- R6: In the shifted phase, a match in the input upper lane counts as already ordered: `order_flag` pulses and the data stays shifted. A match in the input lower lane is ignored.
- R7: Automatic mode (MANUAL=0): an operation happens only on a valid word while `sync_ok` is high, and at most once per interval of `sync_ok` being high. Matches while `sync_ok` is low, or after that one operation, are ignored. When `sync_ok` is low the block returns to the direct phase and re-arms.
- R8: Manual mode (MANUAL=1): a rising edge on `order_en` arms exactly one operation, and a high level lasting a single cycle is enough. Holding `order_en` high does not arm a further operation; it must go low and then high again. `sync_ok` has no effect in this mode.
- R9: A cycle with `in_valid` low changes neither the phase, the held symbol nor the armed state, and never triggers an operation.
- R10: `order_flag` is high only together with `out_valid`, for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 2*SYM_W | Deserialized word; lower lane arrived first |
| sync_ok | input | 1 | Link synchronised (automatic mode trigger) |
| order_en | input | 1 | Manual ordering request, rising-edge armed |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | 2*SYM_W | Lane-ordered output word |
| order_flag | output | 1 | One-cycle pulse with the word of an ordering operation |

## Verification
The checker watches several properties on every cycle. It confirms the one-cycle valid delay and the direct-phase pass-through. It confirms that a pad in the lower lane under the flag is followed on the next valid word by the ordering symbol in the lower lane, that the flag never appears without valid, and the per-mode trigger conditions: sync high in automatic mode, and the enable having gone low between two operations in manual mode. Some behaviours depend on the exact word sequence, and only the bench scenarios can show them. These are the held-over upper symbol across valid gaps, the re-arming and phase clear on loss of sync, and the choice between keep, pad and ignore as the pattern is swept across word positions and lanes.

// File: rtl/rx_lane_order_pkg.sv
package rx_lane_order_pkg;

   localparam int LANES = 2;

   typedef enum logic [1:0] {
      ORD_NONE = 2'd0,
      ORD_KEEP = 2'd1,
      ORD_PAD  = 2'd2
   } ord_op_e;

endpackage

// File: rtl/rx_lane_match.sv
module rx_lane_match #(
   parameter int                SYM_W     = 10,
   parameter int                LANES     = 2,
   parameter logic [SYM_W-1:0]  ORDER_SYM = '0
) (
   input  logic [LANES*SYM_W-1:0] word_i,
   output logic [LANES-1:0]       hit_o
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign hit_o[g] = (word_i[g*SYM_W +: SYM_W] == ORDER_SYM);
   end

endmodule

// File: rtl/rx_order_arm.sv
module rx_order_arm #(
   parameter bit MANUAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_ok_i,
   input  logic order_en_i,
   input  logic op_done_i,
   output logic req_o,
   output logic clr_o
);

   if (MANUAL) begin : g_manual
      logic en_q;
      logic armed_q;
      logic rise;
      logic unused_sync;

      assign unused_sync = sync_ok_i;
      assign rise        = order_en_i & ~en_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q    <= 1'b0;
            armed_q <= 1'b0;
         end else begin
            en_q    <= order_en_i;
            armed_q <= (armed_q | rise) & ~op_done_i;
         end
      end

      assign req_o = armed_q | rise;
      assign clr_o = 1'b0;
   end else begin : g_auto
      logic armed_q;
      logic unused_en;

      assign unused_en = order_en_i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed_q <= 1'b1;
         end else if (!sync_ok_i) begin
            armed_q <= 1'b1;
         end else if (op_done_i) begin
            armed_q <= 1'b0;
         end
      end

      assign req_o = armed_q & sync_ok_i;
      assign clr_o = ~sync_ok_i;
   end

endmodule

// File: rtl/rx_lane_shift.sv
module rx_lane_shift
   import rx_lane_order_pkg::*;
#(
   parameter int               SYM_W   = 10,
   parameter logic [SYM_W-1:0] PAD_SYM = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid_i,
   input  logic [2*SYM_W-1:0]   in_data_i,
   input  ord_op_e              op_i,
   input  logic                 clr_i,
   output logic                 out_valid_o,
   output logic [2*SYM_W-1:0]   out_data_o,
   output logic                 flag_o,
   output logic                 phase_o
);

   localparam int WORD_W = 2 * SYM_W;

   logic             phase_q;
   logic             phase_eff;
   logic [SYM_W-1:0] hold_q;
   logic [SYM_W-1:0] sym_lo;
   logic [SYM_W-1:0] sym_hi;

   assign sym_lo    = in_data_i[SYM_W-1:0];
   assign sym_hi    = in_data_i[WORD_W-1:SYM_W];
   assign phase_eff = phase_q & ~clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= 1'b0;
         hold_q      <= '0;
         out_valid_o <= 1'b0;
         out_data_o  <= '0;
         flag_o      <= 1'b0;
      end else begin
         out_valid_o <= in_valid_i;
         flag_o      <= in_valid_i & (op_i != ORD_NONE);
         if (clr_i) begin
            phase_q <= 1'b0;
         end
         if (in_valid_i) begin
            hold_q <= sym_hi;
            if (phase_eff) begin
               out_data_o <= {sym_lo, hold_q};
            end else if (op_i == ORD_PAD) begin
               out_data_o <= {sym_lo, PAD_SYM};
               phase_q    <= 1'b1;
            end else begin
               out_data_o <= in_data_i;
            end
         end
      end
   end

   assign phase_o = phase_q;

endmodule

// File: rtl/rx_lane_orderer.sv
module rx_lane_orderer
   import rx_lane_order_pkg::*;
#(
   parameter int               SYM_W     = 10,
   parameter logic [SYM_W-1:0] ORDER_SYM = 10'h17C,
   parameter logic [SYM_W-1:0] PAD_SYM   = 10'h09C,
   parameter bit               MANUAL    = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [2*SYM_W-1:0]   in_data,
   input  logic                 sync_ok,
   input  logic                 order_en,
   output logic                 out_valid,
   output logic [2*SYM_W-1:0]   out_data,
   output logic                 order_flag
);

   if (!(SYM_W == 8 || SYM_W == 10)) begin : g_bad_width
      $error("rx_lane_orderer: SYM_W must be 8 or 10");
   end
   if (ORDER_SYM == PAD_SYM) begin : g_bad_pad
      $error("rx_lane_orderer: PAD_SYM must differ from ORDER_SYM");
   end

   logic [LANES-1:0] hit;
   logic             req;
   logic             clr;
   logic             phase;
   logic             op_done;
   ord_op_e          op;

   rx_lane_match #(
      .SYM_W     (SYM_W),
      .LANES     (LANES),
      .ORDER_SYM (ORDER_SYM)
   ) u_match (
      .word_i (in_data),
      .hit_o  (hit)
   );

   rx_order_arm #(
      .MANUAL (MANUAL)
   ) u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_ok_i  (sync_ok),
      .order_en_i (order_en),
      .op_done_i  (op_done),
      .req_o      (req),
      .clr_o      (clr)
   );

   always_comb begin
      op = ORD_NONE;
      if (in_valid && req) begin
         if (!phase) begin
            if (hit[0]) begin
               op = ORD_KEEP;
            end else if (hit[1]) begin
               op = ORD_PAD;
            end
         end else if (hit[1]) begin
            op = ORD_KEEP;
         end
      end
   end

   assign op_done = (op != ORD_NONE);

   rx_lane_shift #(
      .SYM_W   (SYM_W),
      .PAD_SYM (PAD_SYM)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid_i  (in_valid),
      .in_data_i   (in_data),
      .op_i        (op),
      .clr_i       (clr),
      .out_valid_o (out_valid),
      .out_data_o  (out_data),
      .flag_o      (order_flag),
      .phase_o     (phase)
   );

endmodule

// File: rtl/rx_lane_orderer_chk.sv
module rx_lane_orderer_chk #(
   parameter int               SYM_W     = 10,
   parameter logic [SYM_W-1:0] ORDER_SYM = 10'h17C,
   parameter logic [SYM_W-1:0] PAD_SYM   = 10'h09C,
   parameter bit               MANUAL    = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [2*SYM_W-1:0]   in_data,
   input logic                 sync_ok,
   input logic                 order_en,
   input logic                 out_valid,
   input logic [2*SYM_W-1:0]   out_data,
   input logic                 order_flag,
   input logic                 phase
);

   logic pend_q;
   logic low_q;
   logic unused_chk;

   assign unused_chk = ^{sync_ok, order_en};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         low_q  <= 1'b1;
      end else begin
         if (order_flag && out_data[SYM_W-1:0] == PAD_SYM) begin
            pend_q <= 1'b1;
         end else if (out_valid) begin
            pend_q <= 1'b0;
         end
         if (order_flag) begin
            low_q <= ~order_en;
         end else begin
            low_q <= low_q | ~order_en;
         end
      end
   end

   // R2
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));

   // R2
   direct_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && !$past(phase) && !phase)
         |-> (out_data == $past(in_data)));

   // R3
   pad_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && order_flag && out_data[SYM_W-1:0] == PAD_SYM)
         |-> (out_data[2*SYM_W-1:SYM_W] == $past(in_data[SYM_W-1:0])));

   // R4
   pattern_follows_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && out_valid) |-> (out_data[SYM_W-1:0] == ORDER_SYM));

   // R10
   flag_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      order_flag |-> out_valid);

   if (MANUAL) begin : g_man_chk
      // R8
      rearm_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && order_flag) |-> $past(low_q));
   end else begin : g_auto_chk
      // R7
      sync_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && order_flag) |-> $past(sync_ok));
   end

endmodule

bind rx_lane_orderer rx_lane_orderer_chk #(
   .SYM_W     (SYM_W),
   .ORDER_SYM (ORDER_SYM),
   .PAD_SYM   (PAD_SYM),
   .MANUAL    (MANUAL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_data    (in_data),
   .sync_ok    (sync_ok),
   .order_en   (order_en),
   .out_valid  (out_valid),
   .out_data   (out_data),
   .order_flag (order_flag),
   .phase      (phase)
);

// File: tb/test_rx_lane_orderer.sv
module test_rx_lane_orderer;

   localparam int         SW  = 8;
   localparam logic [7:0] ORD = 8'hBC;
   localparam logic [7:0] PAD = 8'h9C;
   localparam int         NW  = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [15:0]   in_data = '0;
   logic          sync_ok = 1'b0;
   logic          order_en = 1'b0;
   logic          a_ov, m_ov, a_of, m_of;
   logic [15:0]   a_od, m_od;

   int checks = 0;
   int errors = 0;
   int cur_j  = 0;
   bit done   = 1'b0;

   logic [7:0]  lo_a [NW];
   logic [7:0]  hi_a [NW];
   logic        v_a  [NW];
   logic        sy_a [NW];
   logic        en_a [NW];
   logic [15:0] ex_d [NW];
   logic        ex_f [NW];
   int          n_w;

   always #5 clk = ~clk;

   rx_lane_orderer #(.SYM_W(SW), .ORDER_SYM(ORD), .PAD_SYM(PAD), .MANUAL(1'b0)) i_rx_lane_orderer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .sync_ok(sync_ok), .order_en(order_en),
      .out_valid(a_ov), .out_data(a_od), .order_flag(a_of));

   rx_lane_orderer #(.SYM_W(SW), .ORDER_SYM(ORD), .PAD_SYM(PAD), .MANUAL(1'b1)) i_rx_lane_orderer_man (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .sync_ok(sync_ok), .order_en(order_en),
      .out_valid(m_ov), .out_data(m_od), .order_flag(m_of));

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s word %0d: actual %h expected %h", tag, cur_j, act, exp);
      end
   endtask

   function automatic logic [7:0] sym(input int n);
      return 8'(n % 100);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; sync_ok = 1'b0; order_en = 1'b0;
      repeat (2) @(negedge clk);
      cur_j = -1;
      check("R1 auto valid", {15'd0, a_ov}, 16'd0);
      check("R1 auto flag",  {15'd0, a_of}, 16'd0);
      check("R1 auto data",  a_od, 16'd0);
      check("R1 man valid",  {15'd0, m_ov}, 16'd0);
      check("R1 man flag",   {15'd0, m_of}, 16'd0);
      rst_n = 1'b1;
   endtask

   task automatic fill(input int n);
      n_w = n;
      for (int j = 0; j < n; j++) begin
         lo_a[j] = sym(2*j); hi_a[j] = sym(2*j + 1);
         v_a[j] = 1'b1; sy_a[j] = 1'b1; en_a[j] = 1'b0;
      end
   endtask

   task automatic expect_direct();
      for (int j = 0; j < n_w; j++) begin
         ex_d[j] = {hi_a[j], lo_a[j]};
         ex_f[j] = 1'b0;
      end
   endtask

   task automatic expect_pad(input int k, input int last_j);
      logic [7:0] held;
      ex_d[k] = {lo_a[k], PAD};
      ex_f[k] = 1'b1;
      held = hi_a[k];
      for (int j = k + 1; j <= last_j; j++) begin
         if (v_a[j]) begin
            ex_d[j] = {lo_a[j], held};
            held = hi_a[j];
         end
      end
   endtask

   task automatic play(input bit sel, input string tag);
      for (int j = 0; j < n_w; j++) begin
         @(negedge clk);
         in_valid = v_a[j]; in_data = {hi_a[j], lo_a[j]};
         sync_ok = sy_a[j]; order_en = en_a[j];
         @(posedge clk);
         #1;
         cur_j = j;
         check("R2", {15'd0, sel ? m_ov : a_ov}, {15'd0, v_a[j]});
         if (v_a[j]) begin
            check(tag, sel ? m_od : a_od, ex_d[j]);
            check(tag, {15'd0, sel ? m_of : a_of}, {15'd0, ex_f[j]});
         end else begin
            check("R10", {15'd0, sel ? m_of : a_of}, 16'd0);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R3 R4 R7: pad position swept, a second pattern is ignored
      for (int k = 0; k < 6; k++) begin
         do_reset();
         fill(10);
         hi_a[k] = ORD; hi_a[k+2] = ORD;
         expect_direct();
         expect_pad(k, 9);
         play(1'b0, "R3 R4 R7");
      end

      // R2 R5 R7: lower-lane pattern (some with both lanes) keeps order
      for (int k = 1; k < 5; k++) begin
         do_reset();
         fill(8);
         lo_a[k] = ORD;
         if (k % 2 == 0) hi_a[k] = ORD;
         hi_a[k+1] = ORD;
         expect_direct();
         ex_f[k] = 1'b1;
         play(1'b0, "R2 R5 R7");
      end

      // R7: sync low ignores, sync loss clears phase and re-arms
      do_reset();
      fill(14);
      sy_a[0] = 1'b0; sy_a[1] = 1'b0; sy_a[2] = 1'b0;
      hi_a[1] = ORD; hi_a[5] = ORD; sy_a[8] = 1'b0; lo_a[10] = ORD;
      expect_direct();
      expect_pad(5, 7);
      ex_f[10] = 1'b1;
      play(1'b0, "R7");

      // R9: valid gaps keep the held symbol; invalid pattern ignored
      do_reset();
      fill(12);
      v_a[1] = 1'b0; hi_a[1] = ORD;
      hi_a[2] = ORD;
      v_a[4] = 1'b0; v_a[5] = 1'b0; v_a[8] = 1'b0;
      expect_direct();
      expect_pad(2, 11);
      play(1'b0, "R9");

      // R6 R8: manual arming, held enable, shifted-phase rules
      do_reset();
      fill(20);
      for (int j = 0; j < 20; j++) sy_a[j] = 1'b0;
      hi_a[1] = ORD;
      en_a[3] = 1'b1;
      hi_a[5] = ORD;
      for (int j = 8; j <= 14; j++) en_a[j] = 1'b1;
      hi_a[9] = ORD; hi_a[11] = ORD;
      en_a[16] = 1'b1;
      lo_a[17] = ORD; hi_a[18] = ORD;
      expect_direct();
      expect_pad(5, 19);
      ex_f[9] = 1'b1; ex_f[18] = 1'b1;
      play(1'b1, "R6 R8");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule